// File: doc/BRIEF.md
# Chainable Serial Boost Setting Register

This block holds the boost settings for a four-lane equalizer. A host moves a 21-bit configuration word in through a slow serial port. The port has a data input, a clock and an active-low load enable. While the enable is low, each bit moves through a shadow chain one stage per clock. When the enable returns high, the whole chain is copied into the active registers in a single step. The last stage of the chain drives a serial output. This lets several devices share one host line: the output of one device feeds the data input of the next.

Active register 1 is an override flag. When it is clear, each lane takes its boost from three strap pins on the board. Pin A has two levels. Pins B and C each have three levels, and the board's sensing logic already delivers them as 2-bit codes. The block looks up the 18-entry strap ladder. When the flag is set, each lane uses its own 5-bit word from the active registers. Holding the mode input low clears every register, which puts all lanes under strap control.

Top module: `boost_cfg_chain`

## Requirements
- R1: Shifting happens only on a rising clock edge while `cfg_mode` is high and `cfg_sen_n` is low. Each bit enters stage 1 and moves one stage toward stage 21 per clock. `cfg_sdo` is stage 21, so a bit appears on `cfg_sdo` 21 shifting edges after it was sampled.
- R2: When more than 21 bits are shifted in, only the last 21 are kept. The first of those 21 ends in register 21 and the last ends in register 1.
- R3: While the enable stays low, the active registers and the outputs keep their previous values.
- R4: While the enable stays high, clock edges change neither the chain nor the active registers, whatever `cfg_sdi` does.
- R5: Register 1 is the override flag. Lane k (k = 0..3) takes registers 2+5k through 6+5k as its boost word, with the lowest-numbered register as the LSB.
- R6: While `cfg_mode` is low, every clock edge clears the chain and the active registers. Shift attempts have no effect, `cfg_sdo` reads 0 and `override_on` reads 0.
- R7: With the flag clear and strap A low, the strap index is 3*B+C, where a code of 00 means low, 01 means middle and 10 means high. The lane boost for index 0..8 is 0, 2, 4, 6, 8, 10, 12, 14, 15.
- R8: With strap A high, index 0..8 gives 16, 17, 19, 21, 23, 24, 26, 28, 31. A strap code of 11 is read as high.
- R9: Pulling `rst_n` low clears the chain and the active registers at once, without waiting for a clock edge.
- R10: A commit takes effect at the first rising edge that samples the enable high after it was sampled low. The outputs show the new values from that edge on. Clearing by mode also shows at the first edge that samples `cfg_mode` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sdi | input | 1 | Serial configuration data in |
| cfg_sen_n | input | 1 | Active-low shift enable; the rising edge commits the chain |
| cfg_mode | input | 1 | High enables serial programming; low clears all registers |
| strap_a | input | 4 | Two-level strap A, one bit per lane |
| strap_b | input | 8 | Three-level strap B, 2-bit code per lane |
| strap_c | input | 8 | Three-level strap C, 2-bit code per lane |
| cfg_sdo | output | 1 | Serial data out for the next device in the chain |
| boost_level | output | 20 | Effective 5-bit boost per lane, lane 0 in the low bits |
| override_on | output | 1 | Serial words are in control |

## Verification
The embedded properties check the following on every cycle:
- the chain holds while the enable is high;
- the chain shifts from `cfg_sdi` while it is low;
- `cfg_sdo` follows stage 20 by one clock;
- the active set equals the chain on the cycle after a release;
- a low mode clears everything;
- steady straps give a steady boost under strap control.

Only the bench scenarios can show the following:
- bit ordering over a complete word, and the last-21-bits rule on long streams;
- the exact values of the strap ladder, including code 11;
- that an asynchronous reset in mid-cycle returns the lanes to strap control.

// File: rtl/boost_cfg_pkg.sv
package boost_cfg_pkg;

   localparam int LVL_W = 5;

   typedef enum logic [1:0] {
      TRI_LOW  = 2'b00,
      TRI_MID  = 2'b01,
      TRI_HIGH = 2'b10,
      TRI_RSV  = 2'b11
   } tri_lvl_e;

   // reserved code folds onto the high level
   function automatic int unsigned tri_rank(tri_lvl_e v);
      case (v)
         TRI_LOW: return 0;
         TRI_MID: return 1;
         default: return 2;
      endcase
   endfunction

   function automatic logic [LVL_W-1:0] strap_to_level(logic a, tri_lvl_e b, tri_lvl_e c);
      int unsigned idx;
      logic [LVL_W-1:0] lvl;
      idx = tri_rank(b) * 3 + tri_rank(c);
      if (!a) begin
         lvl = (idx == 8) ? LVL_W'(15) : LVL_W'(idx * 2);
      end else begin
         case (idx)
            0:       lvl = LVL_W'(16);
            5:       lvl = LVL_W'(24);
            8:       lvl = LVL_W'(31);
            6, 7:    lvl = LVL_W'(14 + idx * 2);
            default: lvl = LVL_W'(15 + idx * 2);
         endcase
      end
      return lvl;
   endfunction

endpackage

// File: rtl/boost_shift_chain.sv
module boost_shift_chain #(
   parameter int LEN = 21
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           shift_en,
   input  logic           din,
   output logic [LEN-1:0] q
);

   if (LEN < 2) begin : g_len_chk
      $error("boost_shift_chain: LEN must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (clr)      q <= '0;
      else if (shift_en) q <= {q[LEN-2:0], din};
   end

   // R6
   chain_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (q == '0));
   // R4
   chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !shift_en) |=> $stable(q));
   // R1
   chain_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && shift_en) |=> (q[0] == $past(din)));

endmodule

// File: rtl/boost_commit_reg.sv
module boost_commit_reg #(
   parameter int LEN = 21
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           clr,
   input  logic           load_n,
   input  logic [LEN-1:0] shadow,
   output logic [LEN-1:0] active
);

   logic load_q;
   logic commit;

   assign commit = load_n && !load_q && !clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) load_q <= 1'b1;
      else        load_q <= load_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      active <= '0;
      else if (clr)    active <= '0;
      else if (commit) active <= shadow;
   end

   // R10
   commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && load_n && !load_q) |=> (active == $past(shadow)));
   // R3
   commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !(load_n && !load_q)) |=> $stable(active));
   // R6
   commit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (active == '0));

endmodule

// File: rtl/boost_lane_select.sv
module boost_lane_select
   import boost_cfg_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int WORD_W = 5
) (
   input  logic                     override,
   input  logic [NUM_CH*WORD_W-1:0] words,
   input  logic [NUM_CH-1:0]        strap_a,
   input  logic [2*NUM_CH-1:0]      strap_b,
   input  logic [2*NUM_CH-1:0]      strap_c,
   output logic [NUM_CH*WORD_W-1:0] level
);

   if (WORD_W != LVL_W) begin : g_width_chk
      $error("boost_lane_select: WORD_W must equal the strap ladder width");
   end

   for (genvar k = 0; k < NUM_CH; k++) begin : g_lane
      logic [WORD_W-1:0] strap_lvl;
      always_comb begin
         strap_lvl = strap_to_level(strap_a[k],
                                    tri_lvl_e'(strap_b[2*k +: 2]),
                                    tri_lvl_e'(strap_c[2*k +: 2]));
      end
      assign level[WORD_W*k +: WORD_W] = override ? words[WORD_W*k +: WORD_W] : strap_lvl;
   end

endmodule

// File: rtl/boost_cfg_chain.sv
module boost_cfg_chain #(
   parameter int NUM_CH = 4,
   parameter int WORD_W = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cfg_sdi,
   input  logic                     cfg_sen_n,
   input  logic                     cfg_mode,
   input  logic [NUM_CH-1:0]        strap_a,
   input  logic [2*NUM_CH-1:0]      strap_b,
   input  logic [2*NUM_CH-1:0]      strap_c,
   output logic                     cfg_sdo,
   output logic [NUM_CH*WORD_W-1:0] boost_level,
   output logic                     override_on
);

   localparam int CHAIN_LEN = 1 + NUM_CH * WORD_W;

   if (NUM_CH < 1) begin : g_ch_chk
      $error("boost_cfg_chain: NUM_CH must be at least 1");
   end

   logic [CHAIN_LEN-1:0] shadow_q;
   logic [CHAIN_LEN-1:0] active_q;
   logic                 mode_clr;

   assign mode_clr = !cfg_mode;

   boost_shift_chain #(.LEN(CHAIN_LEN)) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (mode_clr),
      .shift_en (!cfg_sen_n),
      .din      (cfg_sdi),
      .q        (shadow_q)
   );

   boost_commit_reg #(.LEN(CHAIN_LEN)) u_commit (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (mode_clr),
      .load_n (cfg_sen_n),
      .shadow (shadow_q),
      .active (active_q)
   );

   boost_lane_select #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_select (
      .override (active_q[0]),
      .words    (active_q[CHAIN_LEN-1:1]),
      .strap_a  (strap_a),
      .strap_b  (strap_b),
      .strap_c  (strap_c),
      .level    (boost_level)
   );

   assign cfg_sdo     = shadow_q[CHAIN_LEN-1];
   assign override_on = active_q[0];

   // R1
   sdo_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode && !cfg_sen_n) |=> (cfg_sdo == $past(shadow_q[CHAIN_LEN-2])));
   // R6
   mode_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_mode |=> (!override_on && !cfg_sdo));
   // R7
   strap_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!override_on && !$past(override_on) && $stable(strap_a) && $stable(strap_b)
       && $stable(strap_c)) |-> $stable(boost_level));

endmodule

// File: tb/boost_cfg_chain_bench.sv
`timescale 1ns/1ps
module boost_cfg_chain_bench;

   localparam int NCH = 4;
   localparam int WW  = 5;
   localparam int LEN = 1 + NCH * WW;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_sdi = 1'b0;
   logic            cfg_sen_n = 1'b1;
   logic            cfg_mode = 1'b0;
   logic [NCH-1:0]  strap_a = '0;
   logic [2*NCH-1:0] strap_b = '0;
   logic [2*NCH-1:0] strap_c = '0;
   logic            cfg_sdo;
   logic [NCH*WW-1:0] boost_level;
   logic            override_on;

   always #2 clk = ~clk;

   boost_cfg_chain u_boost_cfg_chain (
      .clk(clk), .rst_n(rst_n), .cfg_sdi(cfg_sdi), .cfg_sen_n(cfg_sen_n),
      .cfg_mode(cfg_mode), .strap_a(strap_a), .strap_b(strap_b), .strap_c(strap_c),
      .cfg_sdo(cfg_sdo), .boost_level(boost_level), .override_on(override_on)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [LEN-1:0] m_sh = '0;
   logic [LEN-1:0] m_act = '0;
   logic           m_prev = 1'b1;

   int ladder_lo[9] = '{0, 2, 4, 6, 8, 10, 12, 14, 15};
   int ladder_hi[9] = '{16, 17, 19, 21, 23, 24, 26, 28, 31};

   function automatic int rank(logic [1:0] v);
      return (v == 2'b00) ? 0 : (v == 2'b01) ? 1 : 2;
   endfunction

   function automatic int strap_expect(int k);
      int i;
      i = rank(strap_b[2*k +: 2]) * 3 + rank(strap_c[2*k +: 2]);
      return strap_a[k] ? ladder_hi[i] : ladder_lo[i];
   endfunction

   function automatic int lane_expect(int k);
      return m_act[0] ? int'(m_act[1 + WW*k +: WW]) : strap_expect(k);
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic check_all(string tag);
      chk(cfg_sdo == m_sh[LEN-1], {tag, " sdo"}, int'(cfg_sdo), int'(m_sh[LEN-1]));
      chk(override_on == m_act[0], {tag, " override"}, int'(override_on), int'(m_act[0]));
      for (int k = 0; k < NCH; k++) begin
         chk(int'(boost_level[WW*k +: WW]) == lane_expect(k), {tag, " lane"},
             int'(boost_level[WW*k +: WW]), lane_expect(k));
      end
   endtask

   task automatic tick(bit sdi, bit sen, bit md, string tag);
      @(negedge clk);
      cfg_sdi = sdi; cfg_sen_n = sen; cfg_mode = md;
      if (!md) begin
         m_sh = '0; m_act = '0;
      end else if (!sen) begin
         m_sh = {m_sh[LEN-2:0], sdi};
      end else if (!m_prev) begin
         m_act = m_sh;
      end
      m_prev = sen;
      @(posedge clk);
      #1;
      check_all(tag);
   endtask

   task automatic send_word(logic [LEN-1:0] v, string tag);
      for (int n = LEN-1; n >= 0; n--) tick(v[n], 1'b0, 1'b1, tag);
   endtask

   function automatic logic [LEN-1:0] make_word(bit ovr, int w0, int w1, int w2, int w3);
      logic [LEN-1:0] v;
      v = {WW'(w3), WW'(w2), WW'(w1), WW'(w0), ovr};
      return v;
   endfunction

   initial begin : watchdog
      #(4.0 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual 0 expected 1");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      logic [LEN-1:0] w;
      void'($urandom(32'd4711));
      strap_a = 4'b1010; strap_b = 8'b01_10_00_01; strap_c = 8'b10_00_01_11;
      repeat (3) @(negedge clk);
      // R9 reset state
      check_all("R9 reset");
      @(negedge clk); rst_n = 1'b1;

      // R7 / R8 strap ladder sweep with mode low
      for (int a = 0; a < 2; a++)
         for (int b = 0; b < 4; b++)
            for (int c = 0; c < 4; c++) begin
               @(negedge clk);
               strap_a = {NCH{a[0]}};
               strap_b = {NCH{b[1:0]}};
               strap_c = {NCH{c[1:0]}};
               #1;
               for (int k = 0; k < NCH; k++) begin
                  int e;
                  e = a ? ladder_hi[rank(b[1:0])*3 + rank(c[1:0])]
                        : ladder_lo[rank(b[1:0])*3 + rank(c[1:0])];
                  chk(int'(boost_level[WW*k +: WW]) == e, a ? "R8 strap" : "R7 strap",
                      int'(boost_level[WW*k +: WW]), e);
               end
            end

      // R1 / R3 / R5 / R10 directed full word
      strap_a = 4'b0101; strap_b = 8'b00_01_10_11; strap_c = 8'b11_10_01_00;
      tick(1'b0, 1'b1, 1'b1, "R10 mode up");
      w = make_word(1'b1, 3, 17, 0, 31);
      send_word(w, "R3 shifting");
      chk(cfg_sdo == w[LEN-1], "R1 first bit at sdo", int'(cfg_sdo), int'(w[LEN-1]));
      chk(override_on == 1'b0, "R3 before commit", int'(override_on), 0);
      tick(1'b0, 1'b1, 1'b1, "R10 commit");
      chk(override_on == 1'b1, "R5 override", int'(override_on), 1);
      chk(boost_level[4:0] == 5'd3, "R5 lane0", int'(boost_level[4:0]), 3);
      chk(boost_level[9:5] == 5'd17, "R5 lane1", int'(boost_level[9:5]), 17);
      chk(boost_level[14:10] == 5'd0, "R5 lane2", int'(boost_level[14:10]), 0);
      chk(boost_level[19:15] == 5'd31, "R5 lane3", int'(boost_level[19:15]), 31);

      // R4 clocks with enable high change nothing
      for (int i = 0; i < 6; i++) tick(1'($urandom), 1'b1, 1'b1, "R4 idle");

      // R2 overlong stream keeps last 21 bits
      for (int i = 0; i < 4; i++) tick(1'b1, 1'b0, 1'b1, "R2 junk");
      w = make_word(1'b1, 9, 22, 5, 12);
      send_word(w, "R2 shifting");
      tick(1'b0, 1'b1, 1'b1, "R10 commit2");
      chk(boost_level == {5'd12, 5'd5, 5'd22, 5'd9}, "R2 last 21 kept",
          int'(boost_level), int'({5'd12, 5'd5, 5'd22, 5'd9}));

      // R6 mode low clears and blocks shifting
      tick(1'b1, 1'b0, 1'b0, "R6 mode low");
      chk(override_on == 1'b0, "R6 cleared", int'(override_on), 0);
      for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, 1'b0, "R6 shift ignored");
      tick(1'b1, 1'b1, 1'b0, "R6 release ignored");

      // R9 asynchronous reset after programming
      tick(1'b0, 1'b1, 1'b1, "R10 mode up2");
      send_word(make_word(1'b1, 30, 1, 2, 4), "R1 shifting");
      tick(1'b0, 1'b1, 1'b1, "R10 commit3");
      @(negedge clk); #1;
      rst_n = 1'b0; m_sh = '0; m_act = '0; m_prev = 1'b1;
      #0.5;
      check_all("R9 async");
      @(negedge clk); rst_n = 1'b1;

      // random phase
      for (int it = 0; it < 60; it++) begin
         int len;
         strap_a = NCH'($urandom); strap_b = (2*NCH)'($urandom); strap_c = (2*NCH)'($urandom);
         len = 10 + int'($urandom_range(20));
         for (int i = 0; i < len; i++)
            tick(1'($urandom), 1'b0, ($urandom_range(15) != 0), "R1 random");
         tick(1'b0, 1'b1, ($urandom_range(7) != 0), "R10 random");
         tick(1'($urandom), 1'b1, 1'b1, "R4 random");
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule